// File: doc/BRIEF.md
# Subsystem DMA Handshake Transfer Controller

This block is the subsystem-facing transfer engine of a serial-bus remote terminal. The protocol logic asks it to move one 16-bit word. Each request carries a direction, a 13-bit word address and, for writes, the data. The block then asks the subsystem for the bus through an active-low request line and waits a bounded number of cycles for an active-low grant. Once granted, it drives an active-low acknowledge, the address, the write strobe and an active-low chip-select. When the transfer is over, it reports completion and any read data back to the protocol logic.

A configuration input chooses word-wide or byte-wide operation. In byte-wide operation a single request/grant exchange carries two chip-select strobes. The upper byte moves first and the lower byte second, and the lowest address bit selects which byte is on the wire. If the grant never comes, the block raises a sticky failure output and the handshake-failure bit of the built-in-test word. It also tells the protocol logic whether the message must be dropped. A read that fails would leave the terminal with nothing valid to transmit, so it is dropped. A write that fails is only flagged.

Top module: `dmah_xfer_ctrl`

## Requirements
- R1: After synchronous reset, `req_n`, `ack_n`, `cs_n`, `wr_n` and `hs_fail_n` are 1; `xfer_done`, `xfer_fail` and `xfer_abort` are 0; `bitw_flags` is 0.
- R2: A `xfer_start` pulse taken while idle drives `req_n` low from the next cycle. A grant (`gnt_n` = 0) is accepted if it is sampled in any of the first GNT_WAIT cycles of the request, counting the first cycle with `req_n` low as cycle 0. Only then does `ack_n` go low.
- R3: `ack_n` goes low at least one cycle before `cs_n` goes low. `req_n` and `ack_n` stay low for as long as `cs_n` is low.
- R4: A read (`xfer_dir` = 0) holds `wr_n` high while `cs_n` is low. The data sampled from `sub_din` at the end of the strobe is presented on `xfer_rdata` while `xfer_done` is high.
- R5: A write (`xfer_dir` = 1) drives `wr_n` low at least one cycle before `cs_n` falls and keeps it low through every strobe. `sub_dout` holds the outgoing data while `cs_n` is low, so the subsystem can latch it on the rising edge of `cs_n`.
- R6: With `byte_mode` = 0, a transfer makes exactly one chip-select strobe with `sub_addr[0]` = 0 and the full word on `sub_dout`/`sub_din`.
- R7: With `byte_mode` = 1, a transfer makes two chip-select strobes under one request. The first has `sub_addr[0]` = 1 and carries bits 15:8 of the word, the second has `sub_addr[0]` = 0 and carries bits 7:0. Each byte travels on data lines 7:0, and a read assembles the two bytes into `xfer_rdata`.
- R8: During every strobe, `sub_addr[13:1]` equals the word address given with the request.
- R9: When a transfer ends, `req_n`, `ack_n` and `cs_n` are all high in the cycle that `xfer_done` or `xfer_fail` is high, and each of these status outputs is a one-cycle pulse.
- R10: If no grant is sampled within GNT_WAIT request cycles, the block pulses `xfer_fail`, makes no chip-select strobe, drives `hs_fail_n` low and sets `bitw_flags[12]`.
- R11: A failed read pulses `xfer_abort` together with `xfer_fail`. A failed write never asserts `xfer_abort`.
- R12: `hs_fail_n` low and `bitw_flags[12]` stay set, across later successful transfers, until a `msg_start` pulse or reset clears them.
- R13: A `xfer_start` pulse that arrives while a transfer is in progress is ignored. It changes neither the current address or data nor the number of requests made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_mode | input | 1 | 1 = two byte strobes per word, 0 = one word strobe |
| msg_start | input | 1 | Pulse at the start of a new message; clears the failure flag |
| xfer_start | input | 1 | Pulse requesting one word transfer |
| xfer_dir | input | 1 | 0 = read from subsystem, 1 = write to subsystem |
| xfer_waddr | input | 13 | Word address of the transfer |
| xfer_wdata | input | 16 | Data to write |
| xfer_done | output | 1 | One-cycle pulse: transfer completed |
| xfer_fail | output | 1 | One-cycle pulse: grant timed out |
| xfer_abort | output | 1 | One-cycle pulse: timed-out read, drop the message |
| xfer_rdata | output | 16 | Word read from the subsystem |
| req_n | output | 1 | Bus request to subsystem, active low |
| gnt_n | input | 1 | Bus grant from subsystem, active low |
| ack_n | output | 1 | Grant acknowledge, active low |
| cs_n | output | 1 | Chip-select strobe, active low |
| wr_n | output | 1 | Direction strobe: low for write, high for read |
| sub_addr | output | 14 | Word address in bits 13:1, byte select in bit 0 |
| sub_dout | output | 16 | Data driven to the subsystem |
| sub_din | input | 16 | Data returned by the subsystem |
| hs_fail_n | output | 1 | Sticky handshake-failure indication, active low |
| bitw_flags | output | 16 | Contribution to the built-in-test word; bit 12 = handshake failure |

## Verification
The bench places the grant on the last cycle of the window and on the first cycle past it. A controller that counted the window one cycle short would fail a legal transfer, and one that counted it one cycle long would complete a transfer that should have timed out. In byte mode it records the order of the byte-select bit and the lane each byte used, which catches a controller that swapped the bytes or re-requested the bus between them. Failed reads and failed writes are run next to each other, so an abort raised for both, or for neither, shows up. A failure followed by a clean transfer, and then by a message start, tests that the failure flag is neither cleared by the clean transfer nor stuck after the message start.

// File: rtl/dmah_pkg.sv
package dmah_pkg;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } xfer_dir_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_SETUP,
        ST_STROBE,
        ST_GAP,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        xfer_dir_e   dir;
        logic        bytes;
        logic [12:0] waddr;
        logic [15:0] wdata;
    } xfer_req_t;

    typedef struct packed {
        logic req_n;
        logic ack_n;
        logic cs_n;
        logic wr_n;
    } bus_ctl_t;

    localparam int HS_BIT_POS = 12;

    // True while the subsystem bus is owned (grant acknowledged).
    function automatic logic st_owns_bus(seq_state_e st);
        return (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_GAP);
    endfunction

    // Control lines for a given sequencer state and direction.
    function automatic bus_ctl_t ctl_for(seq_state_e st, xfer_dir_e dir);
        bus_ctl_t c;
        c.req_n = !((st == ST_REQ) || st_owns_bus(st));
        c.ack_n = !st_owns_bus(st);
        c.cs_n  = !(st == ST_STROBE);
        c.wr_n  = !(st_owns_bus(st) && (dir == DIR_WRITE));
        return c;
    endfunction

    function automatic logic [7:0] pick_byte(logic [15:0] w, logic upper);
        return upper ? w[15:8] : w[7:0];
    endfunction

endpackage

// File: rtl/dmah_grant_timer.sv
module dmah_grant_timer #(
    parameter int GNT_WAIT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic win_last
);
    localparam int CW = $clog2(GNT_WAIT + 1);
    localparam logic [CW-1:0] LAST = CW'(GNT_WAIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign win_last = arm && (cnt == LAST);

    // R10: the window counter never runs past the last allowed cycle
    p_window_bounded_r10: assert property (@(posedge clk) disable iff (rst)
        arm |-> (cnt <= LAST));

endmodule

// File: rtl/dmah_strobe_seq.sv
module dmah_strobe_seq
    import dmah_pkg::*;
#(
    parameter int CS_LEN = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  xfer_req_t   req,
    input  logic        gnt_n,
    input  logic        win_last,
    input  logic [15:0] din,
    output bus_ctl_t    ctl,
    output logic [13:0] addr,
    output logic [15:0] dout,
    output logic        arm,
    output logic        tmo_evt,
    output logic        done,
    output logic        fail,
    output xfer_dir_e   cur_dir,
    output logic [15:0] rdata
);
    localparam int SW = $clog2(CS_LEN + 1);
    localparam logic [SW-1:0] S_LAST = SW'(CS_LEN - 1);

    seq_state_e    st;
    xfer_req_t     cur;
    logic          upper;
    logic [SW-1:0] scnt;
    logic          strobe_end;

    assign strobe_end = (st == ST_STROBE) && (scnt == S_LAST);
    assign tmo_evt    = (st == ST_REQ) && gnt_n && win_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cur   <= '0;
            upper <= 1'b0;
            scnt  <= '0;
            rdata <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        cur   <= req;
                        upper <= req.bytes;
                        st    <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (!gnt_n) begin
                        st <= ST_SETUP;
                    end else if (win_last) begin
                        st <= ST_FAIL;
                    end
                end
                ST_SETUP: begin
                    scnt <= '0;
                    st   <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (strobe_end) begin
                        if (!cur.bytes) begin
                            rdata <= din;
                        end else if (upper) begin
                            rdata[15:8] <= din[7:0];
                        end else begin
                            rdata[7:0] <= din[7:0];
                        end
                        if (cur.bytes && upper) begin
                            upper <= 1'b0;
                            st    <= ST_GAP;
                        end else begin
                            st <= ST_DONE;
                        end
                    end else begin
                        scnt <= scnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    scnt <= '0;
                    st   <= ST_STROBE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ctl     = ctl_for(st, cur.dir);
    assign addr    = {cur.waddr, cur.bytes & upper};
    assign dout    = cur.bytes ? {8'h00, pick_byte(cur.wdata, upper)} : cur.wdata;
    assign arm     = (st == ST_REQ);
    assign done    = (st == ST_DONE);
    assign fail    = (st == ST_FAIL);
    assign cur_dir = cur.dir;

    // R2: acknowledge only follows a sampled grant
    p_ack_after_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.ack_n) |-> ($past(gnt_n) == 1'b0));

    // R3: chip-select never falls in the same cycle as acknowledge
    p_ack_leads_cs_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.cs_n) |-> $past(!ctl.ack_n));

    // R5: direction strobe is settled before chip-select falls
    p_wr_settled_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.cs_n) |-> $stable(ctl.wr_n));

    // R7: after the upper byte strobe, a byte transfer is not yet complete
    p_upper_then_lower_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctl.cs_n) && $past(addr[0])) |-> !done);

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/dmah_fail_flag.sv
module dmah_fail_flag (
    input  logic clk,
    input  logic rst,
    input  logic fail_evt,
    input  logic msg_start,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (fail_evt) begin
            flag <= 1'b1;
        end else if (msg_start) begin
            flag <= 1'b0;
        end
    end

    // R12: the flag holds until a message start
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (flag && !msg_start) |=> flag);

    // R12: a message start without a new failure clears the flag
    p_flag_clear_r12: assert property (@(posedge clk) disable iff (rst)
        (msg_start && !fail_evt) |=> !flag);

endmodule

// File: rtl/dmah_xfer_ctrl.sv
module dmah_xfer_ctrl
    import dmah_pkg::*;
#(
    parameter int GNT_WAIT = 6,
    parameter int CS_LEN   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_mode,
    input  logic        msg_start,
    input  logic        xfer_start,
    input  logic        xfer_dir,
    input  logic [12:0] xfer_waddr,
    input  logic [15:0] xfer_wdata,
    output logic        xfer_done,
    output logic        xfer_fail,
    output logic        xfer_abort,
    output logic [15:0] xfer_rdata,
    output logic        req_n,
    input  logic        gnt_n,
    output logic        ack_n,
    output logic        cs_n,
    output logic        wr_n,
    output logic [13:0] sub_addr,
    output logic [15:0] sub_dout,
    input  logic [15:0] sub_din,
    output logic        hs_fail_n,
    output logic [15:0] bitw_flags
);
    xfer_req_t  req;
    bus_ctl_t   ctl;
    xfer_dir_e  cur_dir;
    logic       arm;
    logic       win_last;
    logic       tmo_evt;
    logic       fail_flag;

    assign req.dir   = xfer_dir_e'(xfer_dir);
    assign req.bytes = byte_mode;
    assign req.waddr = xfer_waddr;
    assign req.wdata = xfer_wdata;

    dmah_grant_timer #(.GNT_WAIT(GNT_WAIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .win_last (win_last)
    );

    dmah_strobe_seq #(.CS_LEN(CS_LEN)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (xfer_start),
        .req      (req),
        .gnt_n    (gnt_n),
        .win_last (win_last),
        .din      (sub_din),
        .ctl      (ctl),
        .addr     (sub_addr),
        .dout     (sub_dout),
        .arm      (arm),
        .tmo_evt  (tmo_evt),
        .done     (xfer_done),
        .fail     (xfer_fail),
        .cur_dir  (cur_dir),
        .rdata    (xfer_rdata)
    );

    dmah_fail_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .fail_evt  (tmo_evt),
        .msg_start (msg_start),
        .flag      (fail_flag)
    );

    assign req_n      = ctl.req_n;
    assign ack_n      = ctl.ack_n;
    assign cs_n       = ctl.cs_n;
    assign wr_n       = ctl.wr_n;
    assign hs_fail_n  = !fail_flag;
    assign bitw_flags = 16'(fail_flag) << HS_BIT_POS;
    assign xfer_abort = xfer_fail && (cur_dir == DIR_READ);

    // R10: a failure pulse is always accompanied by the failure output
    p_fail_flagged_r10: assert property (@(posedge clk) disable iff (rst)
        xfer_fail |-> !hs_fail_n);

    // R11: abort only ever comes with a failure
    p_abort_is_fail_r11: assert property (@(posedge clk) disable iff (rst)
        xfer_abort |-> xfer_fail);

    // R9: status pulses come with all handshake lines released
    p_lines_released_r9: assert property (@(posedge clk) disable iff (rst)
        (xfer_done || xfer_fail) |-> (req_n && ack_n && cs_n));

endmodule

// File: tb/dmah_xfer_ctrl_tb.sv
module dmah_xfer_ctrl_tb;
    localparam int GNT_WAIT = 6;
    localparam int CS_LEN   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_mode = 1'b0;
    logic        msg_start = 1'b0;
    logic        xfer_start = 1'b0;
    logic        xfer_dir = 1'b0;
    logic [12:0] xfer_waddr = '0;
    logic [15:0] xfer_wdata = '0;
    logic        xfer_done, xfer_fail, xfer_abort;
    logic [15:0] xfer_rdata;
    logic        req_n, ack_n, cs_n, wr_n;
    logic        gnt_n = 1'b1;
    logic [13:0] sub_addr;
    logic [15:0] sub_dout;
    logic [15:0] sub_din = 16'hDEAD;
    logic        hs_fail_n;
    logic [15:0] bitw_flags;

    always #2.5 clk = ~clk;

    dmah_xfer_ctrl #(.GNT_WAIT(GNT_WAIT), .CS_LEN(CS_LEN)) u_dut (
        .clk(clk), .rst(rst), .byte_mode(byte_mode), .msg_start(msg_start),
        .xfer_start(xfer_start), .xfer_dir(xfer_dir), .xfer_waddr(xfer_waddr),
        .xfer_wdata(xfer_wdata), .xfer_done(xfer_done), .xfer_fail(xfer_fail),
        .xfer_abort(xfer_abort), .xfer_rdata(xfer_rdata), .req_n(req_n),
        .gnt_n(gnt_n), .ack_n(ack_n), .cs_n(cs_n), .wr_n(wr_n),
        .sub_addr(sub_addr), .sub_dout(sub_dout), .sub_din(sub_din),
        .hs_fail_n(hs_fail_n), .bitw_flags(bitw_flags)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    function automatic logic [15:0] mword(logic [12:0] a);
        return 16'({a, 3'b101} ^ 16'h6C31);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Subsystem monitor / responder
    int          strobes, done_cnt, fail_cnt, abort_cnt, req_falls;
    int          v_r3, v_r4, v_r5, v_r9;
    logic [13:0] st_addr [2];
    logic [15:0] st_data [2];
    logic [15:0] rdata_at_done;
    logic        prev_cs = 1'b1, prev_wr = 1'b1, prev_done = 1'b0, prev_fail = 1'b0;
    logic        prev_req = 1'b1;

    task automatic clear_mon();
        strobes = 0; done_cnt = 0; fail_cnt = 0; abort_cnt = 0; req_falls = 0;
        v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r9 = 0;
        st_addr[0] = '0; st_addr[1] = '0; st_data[0] = '0; st_data[1] = '0;
        rdata_at_done = '0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_req && !req_n) req_falls++;
            if (prev_cs && !cs_n) begin
                if (strobes < 2) st_addr[strobes] = sub_addr;
                strobes++;
                if (prev_wr != wr_n) v_r5++;
                if (prev_cs && ack_n) v_r3++;
            end
            if (!cs_n) begin
                if (ack_n || req_n) v_r3++;
                if (!wr_n && strobes >= 1 && strobes <= 2) st_data[strobes-1] = sub_dout;
                sub_din = sub_addr[0] ? {8'hEE, mword(sub_addr[13:1])[15:8]}
                                      : (byte_mode ? {8'hEE, mword(sub_addr[13:1])[7:0]}
                                                   : mword(sub_addr[13:1]));
            end else begin
                sub_din = 16'hDEAD;
            end
            if (xfer_done) begin
                done_cnt++;
                rdata_at_done = xfer_rdata;
            end
            if (xfer_fail) fail_cnt++;
            if (xfer_abort) abort_cnt++;
            if ((xfer_done || xfer_fail) && (!req_n || !ack_n || !cs_n)) v_r9++;
            if ((xfer_done && prev_done) || (xfer_fail && prev_fail)) v_r9++;
            prev_cs = cs_n; prev_wr = wr_n; prev_done = xfer_done;
            prev_fail = xfer_fail; prev_req = req_n;
        end
    end

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            summary_and_end();
        end
    end

    task automatic run_xfer(input logic dir, input logic bytes, input int gd,
                            input logic [12:0] a, input logic [15:0] wd,
                            input logic dup_start);
        @(negedge clk);
        clear_mon();
        xfer_dir = dir; byte_mode = bytes; xfer_waddr = a; xfer_wdata = wd;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        for (int g = 0; g < 20 && req_n; g++) @(negedge clk);
        if (dup_start) begin
            xfer_waddr = ~a; xfer_wdata = ~wd; xfer_start = 1'b1;
            @(negedge clk);
            xfer_start = 1'b0;
            gd = gd - 1;
        end
        for (int g = 0; g < gd; g++) @(negedge clk);
        gnt_n = 1'b0;
        for (int g = 0; g < 100 && done_cnt == 0 && fail_cnt == 0; g++) @(negedge clk);
        gnt_n = 1'b1;
        for (int g = 0; g < 4; g++) @(negedge clk);
    endtask

    task automatic pulse_msg_start();
        @(negedge clk);
        msg_start = 1'b1;
        @(negedge clk);
        msg_start = 1'b0;
    endtask

    typedef struct packed {
        logic        dir;
        logic        bytes;
        logic [3:0]  gd;
        logic [12:0] addr;
        logic [15:0] wd;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 4'd0, 13'h0123, 16'h0000},
        '{1'b1, 1'b0, 4'd2, 13'h1ABC, 16'hBEEF},
        '{1'b0, 1'b1, 4'd5, 13'h0F0F, 16'h0000},
        '{1'b1, 1'b1, 4'd1, 13'h1555, 16'hA55A},
        '{1'b0, 1'b0, 4'd6, 13'h0042, 16'h0000},
        '{1'b1, 1'b0, 4'd6, 13'h0777, 16'h1234},
        '{1'b1, 1'b1, 4'd9, 13'h0A0A, 16'h5678},
        '{1'b0, 1'b1, 4'd3, 13'h1FFF, 16'h0000}
    };

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk({req_n, ack_n, cs_n, wr_n, hs_fail_n} == 5'b11111, "R1 lines", 
            {27'd0, req_n, ack_n, cs_n, wr_n, hs_fail_n}, 32'h1F);
        chk({xfer_done, xfer_fail, xfer_abort} == 3'b000, "R1 status",
            {29'd0, xfer_done, xfer_fail, xfer_abort}, 32'h0);
        chk(bitw_flags == 16'h0000, "R1 bitw", {16'd0, bitw_flags}, 32'h0);

        foreach (VECS[i]) begin
            automatic vec_t v = VECS[i];
            automatic bit   exp_fail = (int'(v.gd) >= GNT_WAIT);
            automatic int   exp_str  = exp_fail ? 0 : (v.bytes ? 2 : 1);
            pulse_msg_start();
            run_xfer(v.dir, v.bytes, int'(v.gd), v.addr, v.wd, 1'b0);
            chk(fail_cnt == int'(exp_fail) && done_cnt == int'(!exp_fail),
                "R2/R10 outcome", {fail_cnt[15:0], done_cnt[15:0]},
                {15'd0, exp_fail, 15'd0, !exp_fail});
            chk(abort_cnt == int'(exp_fail && !v.dir), "R11 abort",
                abort_cnt, {31'd0, exp_fail && !v.dir});
            chk(strobes == exp_str, v.bytes ? "R7 strobes" : "R6 strobes",
                strobes, exp_str);
            chk(req_falls == 1, "R7 one request", req_falls, 1);
            chk(v_r3 == 0, "R3 ack/req around cs", v_r3, 0);
            chk(v_r9 == 0, "R9 release and pulse", v_r9, 0);
            chk(hs_fail_n == !exp_fail && bitw_flags == (exp_fail ? 16'h1000 : 16'h0),
                "R10 flag", {15'd0, hs_fail_n, bitw_flags},
                {15'd0, !exp_fail, exp_fail ? 16'h1000 : 16'h0});
            if (!exp_fail) begin
                chk(st_addr[0][13:1] == v.addr, "R8 address", st_addr[0], {v.addr, 1'b0});
                if (v.bytes) begin
                    chk(st_addr[0][0] == 1'b1 && st_addr[1][0] == 1'b0 &&
                        st_addr[1][13:1] == v.addr, "R7 byte order",
                        {st_addr[0], st_addr[1]}, {v.addr, 1'b1, v.addr, 1'b0});
                end else begin
                    chk(st_addr[0][0] == 1'b0, "R6 byte select", st_addr[0][0], 0);
                end
                if (!v.dir) begin
                    chk(rdata_at_done == mword(v.addr), "R4 read data",
                        rdata_at_done, mword(v.addr));
                end else begin
                    chk(v_r5 == 0, "R5 wr before cs", v_r5, 0);
                    if (v.bytes)
                        chk(st_data[0] == {8'h00, v.wd[15:8]} && st_data[1] == {8'h00, v.wd[7:0]},
                            "R7 write bytes", {st_data[0], st_data[1]},
                            {8'h00, v.wd[15:8], 8'h00, v.wd[7:0]});
                    else
                        chk(st_data[0] == v.wd, "R5 write data", st_data[0], v.wd);
                end
            end
        end

        // R12: flag survives a successful transfer, then msg_start clears it
        pulse_msg_start();
        run_xfer(1'b0, 1'b0, GNT_WAIT, 13'h0010, 16'h0, 1'b0);
        run_xfer(1'b1, 1'b0, 0, 13'h0011, 16'hCAFE, 1'b0);
        chk(done_cnt == 1 && !hs_fail_n && bitw_flags == 16'h1000, "R12 sticky",
            {15'd0, hs_fail_n, bitw_flags}, {16'd0, 16'h1000});
        pulse_msg_start();
        @(negedge clk);
        chk(hs_fail_n && bitw_flags == 16'h0, "R12 clear",
            {15'd0, hs_fail_n, bitw_flags}, {15'd0, 1'b1, 16'h0});

        // R13: start during a transfer is ignored
        run_xfer(1'b1, 1'b0, 3, 13'h0ABC, 16'h1357, 1'b1);
        for (int g = 0; g < 20; g++) @(negedge clk);
        chk(done_cnt == 1 && req_falls == 1 && strobes == 1, "R13 single transfer",
            {req_falls[15:0], strobes[15:0]}, {16'd1, 16'd1});
        chk(st_addr[0] == {13'h0ABC, 1'b0} && st_data[0] == 16'h1357, "R13 data kept",
            {st_addr[0][13:0], st_data[0]}, {13'h0ABC, 1'b0, 16'h1357});

        summary_and_end();
    end
endmodule